// File: doc/BRIEF.md
# Bus-Master Disk DMA Status and Descriptor Pointer Registers

This block holds the status byte and the descriptor table pointer of a bus-master disk-channel DMA engine. Software reaches it through a small word-addressed register port with byte-lane enables, a write strobe and a read strobe. The DMA engine reports its events on single-cycle pulse inputs: a command start, a command stop, the last transfer of an end-of-table region, a bus abort and a completed descriptor that asked for an interrupt. The drive's interrupt line arrives asynchronously.

The status byte combines read-only, read/write, write-one-to-clear and reserved bits. Two small state machines shape it. The run machine has the states RUN_IDLE and RUN_BUSY. The transition START moves it from RUN_IDLE to RUN_BUSY. The transitions FINISH (end-of-table done) and HALT (stop) move it back to RUN_IDLE. The line machine tracks the synchronized drive line with the states LINE_LOW and LINE_HIGH. Its transition RISE (LINE_LOW to LINE_HIGH) produces a single-cycle capture pulse, and its transition FALL (LINE_HIGH to LINE_LOW) re-arms it. The block raises one interrupt request output whenever either interrupt-bearing flag is set.

Top module: `dma_stat_regs`

## Requirements
- R1: After reset the status byte reads 00h, the pointer reads 0 and `irq_out` is 0.
- R2: Status bit 0 (active) sets one cycle after an `ev_start` pulse while idle and `ev_stop` is low. Software writes to bit 0 are ignored.
- R3: The active bit clears one cycle after `ev_eot_done` or `ev_stop` while running. If `ev_start` and `ev_stop` arrive together while idle, the bit stays 0.
- R4: Status bit 1 (error) sets on an `ev_bus_abort` pulse. Writing 1 to bit 1 clears it, and writing 0 to it has no effect.
- R5: Status bit 2 (interrupt) sets only on a rising edge of `drive_irq`. That edge is seen after a synchronizer of `SYNC_STAGES` flops. Writing 1 clears the bit, and it stays clear while the line stays high until the line falls and rises again.
- R6: Status bit 7 (descriptor done) sets on an `ev_desc_irq` pulse and clears on a write of 1.
- R7: When a hardware set and a software write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R8: Status bits 6 and 5 are plain read/write flags and have no effect on any other bit or on `irq_out`.
- R9: Status bits 4:3 always read 0, and so do the unused byte lanes 0, 1 and 3 of word 0. The status byte changes by write only when byte enable 2 is set.
- R10: Word 1 is the pointer. Bits 31:2 are written per byte lane under `reg_be`, and bits 1:0 always read 0.
- R11: `irq_out` is 1 exactly when status bit 2 or status bit 7 is set.
- R12: Word 0 carries the status byte in byte lane 2 (bits 23:16, byte offset 02h), and word 1 is the pointer (byte offset 04h). `reg_rdata` is loaded on the clock edge at which `reg_rd` is sampled high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Word address: 0 status word, 1 pointer |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| ev_start | input | 1 | Command start pulse |
| ev_stop | input | 1 | Command stop pulse |
| ev_eot_done | input | 1 | Last transfer of an end-of-table region done |
| ev_bus_abort | input | 1 | Bus transfer ended in target or master abort |
| ev_desc_irq | input | 1 | Descriptor with interrupt request completed |
| drive_irq | input | 1 | Asynchronous drive interrupt line |
| irq_out | output | 1 | Interrupt request, OR of status bits 2 and 7 |

## Verification
The bench sweeps all 256 status write values with every clearable flag set beforehand. A design that mixed up write-one-to-clear and plain write polarity, or that let the active or reserved bits take write data, would miscompare in that sweep. It clears the interrupt flag while the drive line stays high and expects the flag to remain clear; a level-sensitive capture would set it again at once. It lines up hardware set events with write-1 clears in the same cycle, where a clear-priority design would drop the event. It also sweeps every byte-enable mask and walking bit on the pointer, where a design that stored the low two bits would break the dword alignment.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    typedef enum logic { RUN_IDLE, RUN_BUSY } run_state_e;
    typedef enum logic { LINE_LOW, LINE_HIGH } line_state_e;

    localparam int STAT_ACT  = 0;
    localparam int STAT_ERR  = 1;
    localparam int STAT_INT  = 2;
    localparam int STAT_CAP0 = 5;
    localparam int STAT_CAP1 = 6;
    localparam int STAT_DESC = 7;
    localparam int STAT_LANE = 2;
    localparam int N_W1C     = 3;

endpackage

// File: rtl/dma_line_edge.sv
module dma_line_edge
    import dma_stat_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              lvl;
    line_state_e       st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], line_async};
    end

    assign lvl = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINE_LOW;
        else        st_q <= st_d;
    end

    // next state and output
    always_comb begin
        st_d = st_q;
        rise = 1'b0;
        unique case (st_q)
            LINE_LOW: if (lvl) begin
                st_d = LINE_HIGH;   // RISE
                rise = 1'b1;
            end
            LINE_HIGH: if (!lvl) st_d = LINE_LOW;  // FALL
            default: st_d = LINE_LOW;
        endcase
    end
endmodule

// File: rtl/dma_run_fsm.sv
module dma_run_fsm
    import dma_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic eot,
    output logic active
);
    run_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RUN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_IDLE: if (start && !stop) st_d = RUN_BUSY;    // START
            RUN_BUSY: if (stop || eot)    st_d = RUN_IDLE;    // HALT / FINISH
            default:  st_d = RUN_IDLE;
        endcase
    end

    always_comb begin
        active = (st_q == RUN_BUSY);
    end
endmodule

// File: rtl/dma_sticky_flag.sv
module dma_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;   // set has priority
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/dma_stat_regs.sv
module dma_stat_regs
    import dma_stat_pkg::*;
#(
    parameter int AW          = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic [3:0]    reg_be,
    input  logic          reg_wr,
    input  logic          reg_rd,
    output logic [31:0]   reg_rdata,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_eot_done,
    input  logic          ev_bus_abort,
    input  logic          ev_desc_irq,
    input  logic          drive_irq,
    output logic          irq_out
);
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam logic [AW-1:0] STAT_WORD = AW'(0);
    localparam logic [AW-1:0] PTR_WORD  = AW'(1);

    logic       stat_we, ptr_wr;
    logic [7:0] stat_wbyte;
    logic       active, line_rise;
    logic [N_W1C-1:0] w1c_set, w1c_clr, w1c_q;
    logic [1:0] cap_q;
    logic [DW-1:0] ptr_q;
    logic [7:0] stat_byte;
    logic [DW-1:0] rd_word;

    assign stat_wbyte = reg_wdata[STAT_LANE*8 +: 8];
    assign stat_we    = reg_wr && (reg_addr == STAT_WORD) && reg_be[STAT_LANE];
    assign ptr_wr     = reg_wr && (reg_addr == PTR_WORD);

    dma_run_fsm u_run (
        .clk(clk), .rst_n(rst_n),
        .start(ev_start), .stop(ev_stop), .eot(ev_eot_done),
        .active(active)
    );

    dma_line_edge #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n),
        .line_async(drive_irq), .rise(line_rise)
    );

    assign w1c_set = {ev_desc_irq, line_rise, ev_bus_abort};

    generate
        for (genvar i = 0; i < N_W1C; i++) begin : g_w1c
            localparam int POS = (i == 0) ? STAT_ERR : (i == 1) ? STAT_INT : STAT_DESC;
            assign w1c_clr[i] = stat_we && stat_wbyte[POS];
            dma_sticky_flag u_flag (
                .clk(clk), .rst_n(rst_n),
                .set(w1c_set[i]), .clr(w1c_clr[i]), .q(w1c_q[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_q <= 2'b00;
        else if (stat_we) cap_q <= {stat_wbyte[STAT_CAP1], stat_wbyte[STAT_CAP0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_wr) begin
            for (int b = 0; b < BW; b++)
                if (reg_be[b]) ptr_q[b*8 +: 8] <= reg_wdata[b*8 +: 8];
            ptr_q[1:0] <= 2'b00;
        end
    end

    always_comb begin
        stat_byte            = '0;
        stat_byte[STAT_ACT]  = active;
        stat_byte[STAT_ERR]  = w1c_q[0];
        stat_byte[STAT_INT]  = w1c_q[1];
        stat_byte[STAT_CAP0] = cap_q[0];
        stat_byte[STAT_CAP1] = cap_q[1];
        stat_byte[STAT_DESC] = w1c_q[2];
        rd_word = '0;
        if (reg_addr == STAT_WORD)     rd_word[STAT_LANE*8 +: 8] = stat_byte;
        else if (reg_addr == PTR_WORD) rd_word = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    assign irq_out = w1c_q[1] | w1c_q[2];
endmodule

// File: rtl/dma_stat_checker.sv
module dma_stat_checker #(
    parameter int AW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [3:0]    reg_be,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [31:0]   reg_rdata,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          ev_eot_done,
    input logic          ev_bus_abort,
    input logic          ev_desc_irq,
    input logic          irq_out,
    input logic          active,
    input logic          line_rise,
    input logic [2:0]    w1c_q
);
    logic clr_int;
    assign clr_int = reg_wr && (reg_addr == AW'(0)) && reg_be[2] && reg_wdata[18];

    assert_start_sets_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !ev_stop && !active) |=> active);

    assert_end_clears_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (ev_stop || ev_eot_done)) |=> !active);

    assert_abort_sets_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_abort |=> w1c_q[0]);

    assert_int_clear_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int && !line_rise) |=> !w1c_q[1]);

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_rise |=> !line_rise);

    assert_desc_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_desc_irq |=> irq_out);

    assert_ptr_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rd) && $past(reg_addr) == AW'(1)) |-> (reg_rdata[1:0] == 2'b00));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_rd) && $past(reg_addr) == AW'(0)) |->
        (reg_rdata[20:19] == 2'b00 && reg_rdata[15:0] == 16'h0 && reg_rdata[31:24] == 8'h0));
endmodule

bind dma_stat_regs dma_stat_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_eot_done(ev_eot_done),
    .ev_bus_abort(ev_bus_abort), .ev_desc_irq(ev_desc_irq), .irq_out(irq_out),
    .active(active), .line_rise(line_rise), .w1c_q(w1c_q)
);

// File: tb/tb_dma_stat_regs.sv
`timescale 1ns/1ps
module tb_dma_stat_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic ev_start = 0, ev_stop = 0, ev_eot_done = 0, ev_bus_abort = 0, ev_desc_irq = 0;
    logic drive_irq = 0;
    logic irq_out;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    dma_stat_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_be(reg_be), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_eot_done(ev_eot_done),
        .ev_bus_abort(ev_bus_abort), .ev_desc_irq(ev_desc_irq),
        .drive_irq(drive_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [0:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd(input logic [0:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic stat(output logic [7:0] s);
        logic [31:0] w;
        rd(1'b0, w);
        s = w[23:16];
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // raise drive line from low with a fresh edge
    task automatic line_edge();
        @(negedge clk); drive_irq = 1'b0;
        wait_n(4);
        drive_irq = 1'b1;
        wait_n(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [7:0]  s;
        logic [7:0]  prev_cap;
        logic [31:0] w;
        wait_n(3);
        rst_n = 1'b1;

        // R1 reset state
        stat(s);  chk("R1 status reset", {24'h0, s}, 32'h0);
        chk("R1 irq_out reset", {31'h0, irq_out}, 32'h0);
        rd(1'b1, w); chk("R1 pointer reset", w, 32'h0);

        // R12 lanes: status only in byte 2 of word 0
        wr(1'b0, 32'h0060_0000, 4'b0100);
        rd(1'b0, w); chk("R12 status lane placement", w, 32'h0060_0000);
        // R9 write with lane 2 disabled changes nothing
        wr(1'b0, 32'hFFFF_FFFF, 4'b1011);
        rd(1'b0, w); chk("R9 lane2 disabled write ignored", w, 32'h0060_0000);
        wr(1'b0, 32'h0000_0000, 4'b0100);

        // R2/R3 active lifecycle
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
        stat(s); chk("R2 active after start", {24'h0, s}, 32'h01);
        wr(1'b0, 32'h0000_0000, 4'b0100);
        stat(s); chk("R2 write 0 to active ignored", {24'h0, s}, 32'h01);
        @(negedge clk); ev_eot_done = 1; @(negedge clk); ev_eot_done = 0;
        stat(s); chk("R3 active clears on eot", {24'h0, s}, 32'h00);
        wr(1'b0, 32'h0001_0000, 4'b0100);
        stat(s); chk("R2 write 1 to active ignored", {24'h0, s}, 32'h00);
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
        @(negedge clk); ev_stop = 1;  @(negedge clk); ev_stop = 0;
        stat(s); chk("R3 active clears on stop", {24'h0, s}, 32'h00);
        @(negedge clk); ev_start = 1; ev_stop = 1; @(negedge clk); ev_start = 0; ev_stop = 0;
        stat(s); chk("R3 start with stop stays idle", {24'h0, s}, 32'h00);
        @(negedge clk); ev_eot_done = 1; @(negedge clk); ev_eot_done = 0;
        stat(s); chk("R3 eot while idle no effect", {24'h0, s}, 32'h00);

        // R5 edge-only capture
        line_edge();
        stat(s); chk("R5 int set on rising edge", {24'h0, s}, 32'h04);
        chk("R11 irq_out from int", {31'h0, irq_out}, 32'h1);
        wr(1'b0, 32'h0004_0000, 4'b0100);
        wait_n(6);
        stat(s); chk("R5 int stays clear while line high", {24'h0, s}, 32'h00);
        chk("R11 irq_out low after clear", {31'h0, irq_out}, 32'h0);
        line_edge();
        stat(s); chk("R5 int sets on new edge", {24'h0, s}, 32'h04);
        wr(1'b0, 32'h0004_0000, 4'b0100);

        // R7 set wins: line edge arrives in the same cycle as a clear
        @(negedge clk); drive_irq = 1'b0; wait_n(4);
        drive_irq = 1'b1;               // N0
        wait_n(2);                      // N2: rise active until next posedge
        reg_addr = 1'b0; reg_wdata = 32'h0004_0000; reg_be = 4'b0100; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_be = '0;
        stat(s); chk("R7 int set beats clear", {24'h0, s}, 32'h04);
        wr(1'b0, 32'h0004_0000, 4'b0100);
        // R7 for error and descriptor flags
        @(negedge clk);
        ev_bus_abort = 1; ev_desc_irq = 1;
        reg_addr = 1'b0; reg_wdata = 32'h0082_0000; reg_be = 4'b0100; reg_wr = 1'b1;
        @(negedge clk); ev_bus_abort = 0; ev_desc_irq = 0; reg_wr = 1'b0; reg_be = '0;
        stat(s); chk("R7 err and desc set beat clear", {24'h0, s}, 32'h82);
        wr(1'b0, 32'h0082_0000, 4'b0100);
        stat(s); chk("R4 R6 write-1 clears", {24'h0, s}, 32'h00);

        // R6 descriptor flag alone drives irq_out (R11)
        @(negedge clk); ev_desc_irq = 1; @(negedge clk); ev_desc_irq = 0;
        chk("R11 irq_out from desc flag", {31'h0, irq_out}, 32'h1);
        stat(s); chk("R6 desc flag set", {24'h0, s}, 32'h80);
        wr(1'b0, 32'h0000_0000, 4'b0100);

        // Sweep all status write values with every flag set (R4 R6 R8 R9 R11)
        prev_cap = 8'h00;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] e;
            @(negedge clk); ev_bus_abort = 1; ev_desc_irq = 1;
            @(negedge clk); ev_bus_abort = 0; ev_desc_irq = 0;
            line_edge();
            stat(s); chk("R4 R5 R6 flags before write", {24'h0, s}, {24'h0, 8'h86 | prev_cap});
            wr(1'b0, {8'h00, 8'(v), 16'h0000}, 4'b0100);
            e = (8'(v) & 8'h60) | (8'h86 & ~8'(v));
            stat(s); chk("R8 R9 status sweep", {24'h0, s}, {24'h0, e});
            chk("R11 irq_out in sweep", {31'h0, irq_out}, {31'h0, (e & 8'h84) != 0});
            prev_cap = 8'(v) & 8'h60;
        end
        wr(1'b0, 32'h0086_0000, 4'b0100);

        // R10 pointer byte enables and alignment
        for (int be = 0; be < 16; be++) begin
            logic [31:0] m;
            wr(1'b1, 32'h0, 4'hF);
            wr(1'b1, 32'hFFFF_FFFF, 4'(be));
            m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & 32'hFFFF_FFFC;
            rd(1'b1, w); chk("R10 pointer byte enables", w, m);
        end
        for (int i = 0; i < 32; i++) begin
            wr(1'b1, 32'h1 << i, 4'hF);
            rd(1'b1, w); chk("R10 pointer walking bit", w, (32'h1 << i) & 32'hFFFF_FFFC);
        end
        // R12 read data holds between reads
        wr(1'b1, 32'h1234_5678, 4'hF);
        wait_n(3);
        chk("R12 rdata holds without read", reg_rdata, 32'h8000_0000);
        rd(1'b1, w); chk("R12 pointer read", w, 32'h1234_5678);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule